// File: doc/BRIEF.md
# Far Jump/Call Privilege Checker

This block decides whether a far jump or far call may proceed. The target is either a code segment named directly or a call gate. Each request arrives as a one-cycle strobe. The strobe carries:

- the current privilege level;
- the 16-bit target selector, whose two low bits are the requested level;
- a flag that tells a call from a jump;
- a flag that tells a gate target from a direct one;
- the 64-bit descriptor the selector names;
- for gate targets only, the level and conforming flag of the destination code segment the gate points to.

One clock later the block returns a registered verdict: allowed or faulted. It also returns the level the code will run at after the transfer, and a request to switch to the stack of that level. For gate targets it also returns the fields it decoded from the gate: parameter count, destination selector and 32-bit entry offset.

The verdict feeds the control-transfer sequencer of a core. Levels are two-bit numbers, and a lower number means more privilege. The caller looks up the descriptors. The caller also does the stack copy that a stack-switch request asks for.

Top module: `farxfer_priv_chk`

## Requirements
- R1: After reset, and until the first request, every output is zero.
- R2: A direct transfer to a nonconforming code segment is allowed only when the requested level is at most the current level and the current level equals the segment level (descriptor bits 46:45). The current level is then kept.
- R3: A direct transfer to a conforming code segment (descriptor bit 42 set) is allowed only when the current level is numerically at least the segment level. The current level is kept.
- R4: A direct target whose descriptor has the present bit (47) clear, the non-system bit (44) clear, or the code bit (43) clear faults.
- R5: A gate transfer faults unless the larger of the current and requested levels is at most the gate level (gate bits 46:45).
- R6: Through a gate to a nonconforming destination, a call needs destination level at most the current level, and a jump needs destination level equal to the current level.
- R7: Through a gate to a conforming destination, the destination level must be at most the current level. The current level is kept, and no stack switch is requested.
- R8: For a gate target the block returns the parameter count from bits 36:32, the destination selector from bits 31:16, and the entry offset from bits 63:48 joined above bits 15:0. For a direct target it returns the input selector, a count of 0 and an offset of 0.
- R9: A gate whose present bit (47) is clear, or whose type in bits 43:40 is not 1100, faults.
- R10: The valid output is high for exactly the cycle after each request strobe. In that cycle exactly one of allow and fault is high, and outside it both are low.
- R11: An allowed call through a gate to a nonconforming destination more privileged than the caller sets the new level to the destination level and requests a stack switch. Every other outcome, including every fault, keeps the current level and requests no switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, one cycle per request |
| cur_pl_i | input | 2 | Current privilege level |
| sel_i | input | 16 | Target selector; bits 1:0 are the requested level |
| is_call_i | input | 1 | 1 = call, 0 = jump |
| via_gate_i | input | 1 | 1 = target is a call gate, 0 = direct code segment |
| desc_i | input | 64 | Descriptor of the target (code segment or gate) |
| dst_pl_i | input | 2 | Level of the gate's destination code segment |
| dst_conf_i | input | 1 | Gate's destination is conforming |
| vld_o | output | 1 | Verdict valid |
| ok_o | output | 1 | Transfer allowed |
| fault_o | output | 1 | Transfer faults |
| new_pl_o | output | 2 | Level after the transfer |
| stk_sw_o | output | 1 | Stack switch requested |
| pcnt_o | output | 5 | Parameter count to copy |
| dsel_o | output | 16 | Destination code selector |
| entry_o | output | 32 | Entry offset |

## Verification
The bench builds the block with its default parameters. These fix 16-bit selectors, 32-bit offsets and 5-bit parameter counts, which is exactly the field layout the gate decoder depends on. With two-bit levels, the whole space of current, requested and segment level combinations is small. The bench therefore sweeps every combination for direct nonconforming and conforming targets, and checks each against the rules. Directed gate cases then cover:

- inward calls that switch stacks;
- jumps refused under the same conditions;
- conforming destinations;
- malformed gates;
- field extraction with distinct bit patterns.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int PL_W   = 2;
  localparam int SEL_W  = 16;
  localparam int OFF_W  = 32;
  localparam int PCNT_W = 5;
  localparam int DESC_W = 64;

  // shared descriptor bit positions
  localparam int B_PRES = 47;
  localparam int B_DPLH = 46;
  localparam int B_DPLL = 45;
  localparam int B_SYSN = 44;
  localparam int B_CODE = 43;
  localparam int B_CONF = 42;
  localparam logic [3:0] GATE_TYPE = 4'b1100;

  typedef logic [PL_W-1:0] lvl_t;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [SEL_W-1:0]  sel;
    logic [PCNT_W-1:0] pcnt;
    lvl_t              dpl;
    logic              present;
    logic [3:0]        typ;
  } gate_t;
endpackage

// File: rtl/pcx_gate_dec.sv
module pcx_gate_dec
  import pcx_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output gate_t             g
);
  localparam int HALF = OFF_W / 2;

  always_comb begin
    g.off     = {desc[DESC_W-1 -: HALF], desc[HALF-1:0]};
    g.sel     = desc[HALF +: SEL_W];
    g.pcnt    = desc[32 +: PCNT_W];
    g.dpl     = desc[B_DPLH:B_DPLL];
    g.present = desc[B_PRES];
    g.typ     = desc[43:40];
  end
endmodule

// File: rtl/pcx_direct_rule.sv
module pcx_direct_rule
  import pcx_pkg::*;
(
  input  lvl_t              cpl,
  input  lvl_t              rpl,
  input  logic [DESC_W-1:0] desc,
  output logic              ok
);
  lvl_t seg_pl;
  logic well_formed;
  logic conf;

  always_comb begin
    seg_pl      = desc[B_DPLH:B_DPLL];
    conf        = desc[B_CONF];
    well_formed = desc[B_PRES] & desc[B_SYSN] & desc[B_CODE];
    if (!well_formed)
      ok = 1'b0;
    else if (conf)
      ok = (cpl >= seg_pl);
    else
      ok = (rpl <= cpl) && (cpl == seg_pl);
  end
endmodule

// File: rtl/pcx_gate_rule.sv
module pcx_gate_rule
  import pcx_pkg::*;
(
  input  lvl_t  cpl,
  input  lvl_t  rpl,
  input  logic  is_call,
  input  gate_t g,
  input  lvl_t  dst_pl,
  input  logic  dst_conf,
  output logic  ok,
  output logic  inward,
  output lvl_t  nxt_pl
);
  lvl_t eff;
  logic gate_ok;
  logic dst_ok;

  always_comb begin
    eff     = (rpl > cpl) ? rpl : cpl;
    gate_ok = g.present && (g.typ == GATE_TYPE) && (eff <= g.dpl);
    if (dst_conf)
      dst_ok = (dst_pl <= cpl);
    else if (is_call)
      dst_ok = (dst_pl <= cpl);
    else
      dst_ok = (dst_pl == cpl);
    ok     = gate_ok && dst_ok;
    inward = ok && is_call && !dst_conf && (dst_pl < cpl);
    nxt_pl = inward ? dst_pl : cpl;
  end
endmodule

// File: rtl/farxfer_priv_chk.sv
module farxfer_priv_chk
  import pcx_pkg::*;
#(
  parameter int P_SEL_W  = SEL_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_PCNT_W = PCNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic [1:0]          cur_pl_i,
  input  logic [P_SEL_W-1:0]  sel_i,
  input  logic                is_call_i,
  input  logic                via_gate_i,
  input  logic [63:0]         desc_i,
  input  logic [1:0]          dst_pl_i,
  input  logic                dst_conf_i,
  output logic                vld_o,
  output logic                ok_o,
  output logic                fault_o,
  output logic [1:0]          new_pl_o,
  output logic                stk_sw_o,
  output logic [P_PCNT_W-1:0] pcnt_o,
  output logic [P_SEL_W-1:0]  dsel_o,
  output logic [P_OFF_W-1:0]  entry_o
);
  lvl_t  rpl;
  gate_t gt;
  logic  d_ok, g_ok, g_in;
  lvl_t  g_pl;
  logic  allow;
  logic  sw;
  lvl_t  npl;

  assign rpl = sel_i[PL_W-1:0];

  pcx_gate_dec u_dec (.desc(desc_i), .g(gt));

  pcx_direct_rule u_dir (
    .cpl(cur_pl_i), .rpl(rpl), .desc(desc_i), .ok(d_ok)
  );

  pcx_gate_rule u_gate (
    .cpl(cur_pl_i), .rpl(rpl), .is_call(is_call_i), .g(gt),
    .dst_pl(dst_pl_i), .dst_conf(dst_conf_i),
    .ok(g_ok), .inward(g_in), .nxt_pl(g_pl)
  );

  always_comb begin
    allow = via_gate_i ? g_ok : d_ok;
    sw    = via_gate_i & g_in;
    npl   = via_gate_i ? g_pl : cur_pl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o    <= 1'b0;
      ok_o     <= 1'b0;
      fault_o  <= 1'b0;
      new_pl_o <= '0;
      stk_sw_o <= 1'b0;
      pcnt_o   <= '0;
      dsel_o   <= '0;
      entry_o  <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        ok_o     <= allow;
        fault_o  <= ~allow;
        new_pl_o <= npl;
        stk_sw_o <= sw;
        if (via_gate_i) begin
          pcnt_o  <= gt.pcnt;
          dsel_o  <= gt.sel;
          entry_o <= gt.off;
        end else begin
          pcnt_o  <= '0;
          dsel_o  <= sel_i;
          entry_o <= '0;
        end
      end else begin
        ok_o    <= 1'b0;
        fault_o <= 1'b0;
      end
    end
  end

  // R10
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> vld_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> (!ok_o && !fault_o));

  // R11
  sw_inward_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (!stk_sw_o || (new_pl_o < $past(cur_pl_i))));

  // R11
  sw_call_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (!stk_sw_o || ($past(is_call_i) && $past(via_gate_i))));

  // R11
  fault_keep_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (!fault_o || (!stk_sw_o && new_pl_o == $past(cur_pl_i))));

endmodule

// File: tb/sim_farxfer_priv_chk.sv
module sim_farxfer_priv_chk;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i = 1'b0;
  logic [1:0]  cur_pl_i = '0;
  logic [15:0] sel_i = '0;
  logic        is_call_i = 1'b0;
  logic        via_gate_i = 1'b0;
  logic [63:0] desc_i = '0;
  logic [1:0]  dst_pl_i = '0;
  logic        dst_conf_i = 1'b0;
  logic        vld_o, ok_o, fault_o, stk_sw_o;
  logic [1:0]  new_pl_o;
  logic [4:0]  pcnt_o;
  logic [15:0] dsel_o;
  logic [31:0] entry_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  farxfer_priv_chk u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .cur_pl_i(cur_pl_i), .sel_i(sel_i),
    .is_call_i(is_call_i), .via_gate_i(via_gate_i), .desc_i(desc_i),
    .dst_pl_i(dst_pl_i), .dst_conf_i(dst_conf_i),
    .vld_o(vld_o), .ok_o(ok_o), .fault_o(fault_o), .new_pl_o(new_pl_o),
    .stk_sw_o(stk_sw_o), .pcnt_o(pcnt_o), .dsel_o(dsel_o), .entry_o(entry_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] code_desc(logic [1:0] dpl, logic conf,
                                            logic pres, logic sysn, logic code);
    logic [63:0] d = 64'h0;
    d[47] = pres; d[46:45] = dpl; d[44] = sysn; d[43] = code; d[42] = conf;
    d[41] = 1'b1;
    return d;
  endfunction

  function automatic logic [63:0] gate_desc(logic [31:0] off, logic [15:0] s,
                                            logic [4:0] pc, logic [1:0] dpl,
                                            logic pres, logic [3:0] typ);
    logic [63:0] d = 64'h0;
    d[15:0] = off[15:0]; d[31:16] = s; d[36:32] = pc; d[43:40] = typ;
    d[46:45] = dpl; d[47] = pres; d[63:48] = off[31:16];
    return d;
  endfunction

  task automatic xfer(logic [1:0] cpl, logic [15:0] s, logic call, logic gate,
                      logic [63:0] d, logic [1:0] dpl, logic dconf);
    @(negedge clk);
    req_i = 1'b1; cur_pl_i = cpl; sel_i = s; is_call_i = call;
    via_gate_i = gate; desc_i = d; dst_pl_i = dpl; dst_conf_i = dconf;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic expect_v(string req, logic ok, logic [1:0] pl, logic sw);
    chk(req, {63'b0, vld_o}, 64'd1);
    chk(req, {62'b0, ok_o, fault_o}, {62'b0, ok, ~ok});
    chk(req, {62'b0, new_pl_o}, {62'b0, pl});
    chk(req, {63'b0, stk_sw_o}, {63'b0, sw});
  endtask

  task automatic t_reset;
    chk("R1", {vld_o, ok_o, fault_o, stk_sw_o, new_pl_o, pcnt_o}, 64'd0);
    chk("R1", {dsel_o, entry_o}, 64'd0);
  endtask

  task automatic t_direct_sweep;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int p = 0; p < 4; p++) begin
          logic e_nc, e_c;
          e_nc = (r <= c) && (c == p);
          xfer(2'(c), {14'h0AB, 2'(r)}, 1'b1, 1'b0,
               code_desc(2'(p), 1'b0, 1'b1, 1'b1, 1'b1), 2'd0, 1'b0);
          expect_v("R2", e_nc, 2'(c), 1'b0);
          e_c = (c >= p);
          xfer(2'(c), {14'h0AB, 2'(r)}, 1'b0, 1'b0,
               code_desc(2'(p), 1'b1, 1'b1, 1'b1, 1'b1), 2'd0, 1'b0);
          expect_v("R3", e_c, 2'(c), 1'b0);
          chk("R8", {48'b0, dsel_o}, {48'b0, 14'h0AB, 2'(r)});
          chk("R8", {27'b0, pcnt_o, entry_o}, 64'd0);
        end
  endtask

  task automatic t_direct_bad;
    xfer(2'd2, 16'h0012, 1'b1, 1'b0, code_desc(2'd2, 1'b0, 1'b0, 1'b1, 1'b1), 2'd0, 1'b0);
    expect_v("R4", 1'b0, 2'd2, 1'b0);
    xfer(2'd2, 16'h0012, 1'b1, 1'b0, code_desc(2'd2, 1'b0, 1'b1, 1'b0, 1'b1), 2'd0, 1'b0);
    expect_v("R4", 1'b0, 2'd2, 1'b0);
    xfer(2'd2, 16'h0012, 1'b1, 1'b0, code_desc(2'd2, 1'b0, 1'b1, 1'b1, 1'b0), 2'd0, 1'b0);
    expect_v("R4", 1'b0, 2'd2, 1'b0);
  endtask

  task automatic t_gate_priv;
    xfer(2'd3, 16'h0043, 1'b1, 1'b1,
         gate_desc(32'h1000_2000, 16'h0008, 5'd0, 2'd3, 1'b1, 4'b1100), 2'd3, 1'b0);
    expect_v("R5", 1'b1, 2'd3, 1'b0);
    xfer(2'd2, 16'h0043, 1'b1, 1'b1,
         gate_desc(32'h1000_2000, 16'h0008, 5'd0, 2'd2, 1'b1, 4'b1100), 2'd0, 1'b0);
    expect_v("R5", 1'b0, 2'd2, 1'b0);
    xfer(2'd1, 16'h0042, 1'b1, 1'b1,
         gate_desc(32'h1000_2000, 16'h0008, 5'd0, 2'd2, 1'b1, 4'b1100), 2'd0, 1'b0);
    expect_v("R5", 1'b1, 2'd0, 1'b1);
  endtask

  task automatic t_gate_nonconf;
    logic [63:0] g = gate_desc(32'hCAFE_F00D, 16'h0010, 5'd3, 2'd3, 1'b1, 4'b1100);
    xfer(2'd3, 16'h0053, 1'b1, 1'b1, g, 2'd0, 1'b0);
    expect_v("R6", 1'b1, 2'd0, 1'b1);
    chk("R11", {62'b0, new_pl_o}, 64'd0);
    xfer(2'd3, 16'h0053, 1'b0, 1'b1, g, 2'd0, 1'b0);
    expect_v("R6", 1'b0, 2'd3, 1'b0);
    xfer(2'd3, 16'h0053, 1'b0, 1'b1, g, 2'd3, 1'b0);
    expect_v("R6", 1'b1, 2'd3, 1'b0);
    xfer(2'd1, 16'h0051, 1'b1, 1'b1, g, 2'd2, 1'b0);
    expect_v("R6", 1'b0, 2'd1, 1'b0);
    xfer(2'd2, 16'h0052, 1'b1, 1'b1, g, 2'd2, 1'b0);
    expect_v("R11", 1'b1, 2'd2, 1'b0);
  endtask

  task automatic t_gate_conf;
    logic [63:0] g = gate_desc(32'h0000_0400, 16'h0018, 5'd2, 2'd3, 1'b1, 4'b1100);
    xfer(2'd3, 16'h0063, 1'b1, 1'b1, g, 2'd0, 1'b1);
    expect_v("R7", 1'b1, 2'd3, 1'b0);
    xfer(2'd3, 16'h0063, 1'b0, 1'b1, g, 2'd1, 1'b1);
    expect_v("R7", 1'b1, 2'd3, 1'b0);
    xfer(2'd1, 16'h0061, 1'b1, 1'b1, g, 2'd3, 1'b1);
    expect_v("R7", 1'b0, 2'd1, 1'b0);
  endtask

  task automatic t_gate_fields;
    xfer(2'd3, 16'h0073, 1'b1, 1'b1,
         gate_desc(32'hA5C3_5A3C, 16'hBEE8, 5'd17, 2'd3, 1'b1, 4'b1100), 2'd0, 1'b0);
    chk("R8", {48'b0, dsel_o}, 64'hBEE8);
    chk("R8", {59'b0, pcnt_o}, 64'd17);
    chk("R8", {32'b0, entry_o}, 64'hA5C3_5A3C);
    xfer(2'd3, 16'h0073, 1'b1, 1'b1,
         gate_desc(32'h0001_FFFE, 16'h1230, 5'd31, 2'd3, 1'b1, 4'b1100), 2'd0, 1'b0);
    chk("R8", {59'b0, pcnt_o}, 64'd31);
    chk("R8", {32'b0, entry_o}, 64'h0001_FFFE);
  endtask

  task automatic t_gate_bad;
    xfer(2'd3, 16'h0083, 1'b1, 1'b1,
         gate_desc(32'h10, 16'h0008, 5'd1, 2'd3, 1'b0, 4'b1100), 2'd0, 1'b0);
    expect_v("R9", 1'b0, 2'd3, 1'b0);
    xfer(2'd3, 16'h0083, 1'b1, 1'b1,
         gate_desc(32'h10, 16'h0008, 5'd1, 2'd3, 1'b1, 4'b1101), 2'd0, 1'b0);
    expect_v("R9", 1'b0, 2'd3, 1'b0);
    xfer(2'd3, 16'h0083, 1'b1, 1'b1,
         gate_desc(32'h10, 16'h0008, 5'd1, 2'd3, 1'b1, 4'b0100), 2'd0, 1'b0);
    expect_v("R9", 1'b0, 2'd3, 1'b0);
  endtask

  task automatic t_latency;
    xfer(2'd0, 16'h0000, 1'b1, 1'b0, code_desc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1), 2'd0, 1'b0);
    expect_v("R10", 1'b1, 2'd0, 1'b0);
    @(negedge clk);
    chk("R10", {61'b0, vld_o, ok_o, fault_o}, 64'd0);
    @(negedge clk);
    chk("R10", {61'b0, vld_o, ok_o, fault_o}, 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct_sweep();
    t_direct_bad();
    t_gate_priv();
    t_gate_nonconf();
    t_gate_conf();
    t_gate_fields();
    t_gate_bad();
    t_latency();
    finish_run();
  end
endmodule